// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block keeps a small first-in, first-out store of code bytes topped up ahead of an instruction consumer. It reads code from a memory port that is 16 bits wide. When its fetch pointer is on an even offset, one access brings in a whole aligned word. When the pointer is odd, the access keeps only the upper byte of the word, and all later fetches are word aligned. The consumer removes one byte at a time and marks whether that byte opens a new instruction. Every removal, and every flush, is reported on a 2-bit status output one cycle later.

A branch request carries a new target offset. It empties the queue, and refilling starts from that target. A fetch that is still waiting on memory when the branch arrives runs to completion, and its data is then dropped. The segment base is added outside the block, so every address here is a 16-bit offset within the code segment. Reset clears the queue and sets the pointer to a parameter whose default is offset 0. With the segment register forced to all ones by the surrounding logic, this places the first fetch at the top 16 bytes of the 1 MB space. Reset must be held for at least 4 clocks.

Top module: `pq_prefetch_queue`

## Requirements
- R1: During and right after reset the queue is empty (`q_valid`=0), `q_status`=00 and `mem_req`=0. The first fetch after reset is issued on the first clock edge with `rst` low, at offset `RESET_OFFSET`.
- R2: Bytes leave the queue in the order of their offsets. `q_byte` shows the oldest byte while `q_valid` is 1, and the queue holds at most `DEPTH` (6) bytes.
- R3: A fetch from an even offset A pushes two bytes in one access: first `mem_rdata[7:0]` (offset A), then `mem_rdata[15:8]` (offset A+1). The next fetch is from A+2.
- R4: A fetch from an odd offset A pushes only `mem_rdata[15:8]` (offset A). The next fetch is from A+1, which is even.
- R5: A fetch is issued only when the queue has room for every byte it will push: two free bytes for an even offset, one for an odd offset.
- R6: Once `mem_req` rises it stays high, with `mem_addr` unchanged, until the clock edge at which `mem_ready` is 1. That edge completes the access.
- R7: A branch request empties the queue at the next clock edge. The next fetch that is issued uses `branch_addr`.
- R8: If a fetch is outstanding when a branch arrives, including one that completes in the same cycle, its data is discarded.
- R9: A removal (`take`=1 while `q_valid`=1) gives `q_status`=01 in the following cycle if `take_first`=1, and 11 if `take_first`=0.
- R10: A branch request gives `q_status`=10 in the following cycle. A `take` in the same cycle removes nothing.
- R11: A `take` while the queue is empty removes nothing. `q_status` is 00 in the following cycle, and the byte that arrives later is still delivered.
- R12: With no consumer activity, fetching continues until the next fetch no longer fits. From a target T the queue then holds the number of bytes that the R3, R4 and R5 rules give (6 from an even T, 5 from an odd T), and `mem_req` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| branch_req | input | 1 | Flush the queue and restart fetching at `branch_addr` |
| branch_addr | input | AW | Branch or start target offset |
| mem_req | output | 1 | Fetch request, held until `mem_ready` |
| mem_addr | output | AW | Byte offset of the fetch; memory returns the aligned word that contains it |
| mem_rdata | input | 16 | Word read data; lower byte is the even offset |
| mem_ready | input | 1 | Read data valid; completes the fetch at this edge |
| take | input | 1 | Remove the head byte |
| take_first | input | 1 | Removed byte opens an instruction |
| q_byte | output | 8 | Head byte of the queue |
| q_valid | output | 1 | Queue not empty |
| q_status | output | 2 | 00 none, 01 first byte taken, 10 flushed, 11 later byte taken |

## Verification
The bench sweeps even and odd targets, including the top of the offset range where the pointer wraps, against memory latencies of zero to two wait cycles. Each target is checked for its fetch address sequence, its idle fill level and its byte stream. The idle fill level is where an odd target stalls one byte short of full. A design that checked only for one free byte would overwrite the head there, and one that fetched whole words from odd offsets would deliver a duplicated even byte first. Branches are placed while a fetch is outstanding, so a design that kept the stale data would put bytes from the old target at the head. A take in the same cycle as a branch, and a take on an empty queue, show whether removals are wrongly reported or bytes are lost.

// File: rtl/pq_pkg.sv
package pq_pkg;

  typedef enum logic [1:0] {
    QS_NONE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qs_e;

  // bytes a fetch at this offset parity will push
  function automatic logic [1:0] fetch_len(input logic odd);
    return odd ? 2'd1 : 2'd2;
  endfunction

  // does a fetch at this parity fit beside 'used' occupied bytes
  function automatic logic fetch_fits(input int unsigned used,
                                      input int unsigned depth,
                                      input logic odd);
    return (used + 32'(fetch_len(odd))) <= depth;
  endfunction

endpackage

// File: rtl/pq_fetch_ctl.sv
module pq_fetch_ctl
  import pq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DEPTH = 6,
  parameter int unsigned CW = 3,
  parameter logic [AW-1:0] RESET_OFFSET = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          branch,
  input  logic [AW-1:0] branch_addr,
  input  logic [CW-1:0] used,
  input  logic          mem_ready,
  input  logic [15:0]   mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    push_cnt,
  output logic [7:0]    push_b0,
  output logic [7:0]    push_b1,
  output logic          fetch_issue,
  output logic          fetch_drop
);

  logic          busy_q;
  logic          discard_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] addr_q;
  logic          fetch_done;

  assign fetch_issue = !busy_q && !branch && fetch_fits(32'(used), DEPTH, ptr_q[0]);
  assign fetch_done  = busy_q && mem_ready;
  assign fetch_drop  = fetch_done && (discard_q || branch);

  assign mem_req  = busy_q;
  assign mem_addr = addr_q;

  assign push_cnt = (fetch_done && !fetch_drop) ? fetch_len(addr_q[0]) : 2'd0;
  assign push_b0  = addr_q[0] ? mem_rdata[15:8] : mem_rdata[7:0];
  assign push_b1  = mem_rdata[15:8];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      discard_q <= 1'b0;
      ptr_q     <= RESET_OFFSET;
      addr_q    <= '0;
    end else begin
      if (branch)
        ptr_q <= branch_addr;
      else if (fetch_done && !discard_q)
        ptr_q <= ptr_q + AW'(fetch_len(addr_q[0]));

      if (fetch_issue)
        addr_q <= ptr_q;

      if (fetch_done)
        busy_q <= 1'b0;
      else if (fetch_issue)
        busy_q <= 1'b1;

      if (fetch_done)
        discard_q <= 1'b0;
      else if (branch && busy_q)
        discard_q <= 1'b1;
    end
  end

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  // R8
  discard_live_chk: assert property (@(posedge clk) disable iff (rst)
    discard_q |-> mem_req);

  // R8
  drop_no_push_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_drop |-> (push_cnt == 2'd0));

endmodule

// File: rtl/pq_byte_fifo.sv
module pq_byte_fifo #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [1:0]    push_cnt,
  input  logic [7:0]    push_b0,
  input  logic [7:0]    push_b1,
  input  logic          pop,
  output logic [7:0]    head,
  output logic [CW-1:0] used,
  output logic          valid
);

  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    store_q [DEPTH];
  logic [IW-1:0] rd_q;
  logic [IW-1:0] wr_q;
  logic [CW-1:0] used_q;

  function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] idx,
                                             input int unsigned step);
    int unsigned s;
    s = 32'(idx) + step;
    if (s >= DEPTH) s = s - DEPTH;
    return IW'(s);
  endfunction

  always_ff @(posedge clk) begin
    if (push_cnt != 2'd0)
      store_q[wr_q] <= push_b0;
    if (push_cnt == 2'd2)
      store_q[wrap_add(wr_q, 1)] <= push_b1;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_q   <= '0;
      wr_q   <= '0;
      used_q <= '0;
    end else begin
      wr_q   <= wrap_add(wr_q, 32'(push_cnt));
      if (pop) rd_q <= wrap_add(rd_q, 1);
      used_q <= used_q + CW'(push_cnt) - CW'(pop);
    end
  end

  assign head  = store_q[rd_q];
  assign used  = used_q;
  assign valid = (used_q != '0);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    32'(used_q) <= DEPTH);

  // R11
  pop_guard_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> valid);

endmodule

// File: rtl/pq_status.sv
module pq_status
  import pq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       branch,
  input  logic       pop,
  input  logic       first,
  output logic [1:0] qs
);

  qs_e qs_q;

  always_ff @(posedge clk) begin
    if (rst)         qs_q <= QS_NONE;
    else if (branch) qs_q <= QS_FLUSH;
    else if (pop)    qs_q <= first ? QS_FIRST : QS_NEXT;
    else             qs_q <= QS_NONE;
  end

  assign qs = qs_q;

  // R10
  flush_code_chk: assert property (@(posedge clk) disable iff (rst)
    branch |=> (qs == 2'b10));

  // R9
  take_code_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !branch) |=> (qs[0] == 1'b1));

endmodule

// File: rtl/pq_prefetch_queue.sv
module pq_prefetch_queue
  import pq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DEPTH = 6,
  parameter logic [AW-1:0] RESET_OFFSET = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          branch_req,
  input  logic [AW-1:0] branch_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_ready,
  input  logic          take,
  input  logic          take_first,
  output logic [7:0]    q_byte,
  output logic          q_valid,
  output logic [1:0]    q_status
);

  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] used;
  logic [1:0]    push_cnt;
  logic [7:0]    push_b0;
  logic [7:0]    push_b1;
  logic          fetch_issue;
  logic          fetch_drop;
  logic          pop;

  assign pop = take && q_valid && !branch_req;

  pq_fetch_ctl #(.AW(AW), .DEPTH(DEPTH), .CW(CW), .RESET_OFFSET(RESET_OFFSET)) fetch_i (
    .clk(clk), .rst(rst), .branch(branch_req), .branch_addr(branch_addr),
    .used(used), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .push_cnt(push_cnt),
    .push_b0(push_b0), .push_b1(push_b1),
    .fetch_issue(fetch_issue), .fetch_drop(fetch_drop)
  );

  pq_byte_fifo #(.DEPTH(DEPTH), .CW(CW)) fifo_i (
    .clk(clk), .rst(rst), .flush(branch_req), .push_cnt(push_cnt),
    .push_b0(push_b0), .push_b1(push_b1), .pop(pop),
    .head(q_byte), .used(used), .valid(q_valid)
  );

  pq_status status_i (
    .clk(clk), .rst(rst), .branch(branch_req), .pop(pop),
    .first(take_first), .qs(q_status)
  );

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    branch_req |=> !q_valid);

  // R5
  issue_fit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> ((32'($past(used)) + 32'(fetch_len(mem_addr[0]))) <= DEPTH));

  // R11
  empty_take_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !q_valid && !branch_req) |=> (q_status == 2'b00));

  // R8
  drop_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_drop && !branch_req) |=> !q_valid);

endmodule

// File: tb/pq_prefetch_queue_tb.sv
module pq_prefetch_queue_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        branch_req = 1'b0;
  logic [15:0] branch_addr = '0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic        take = 1'b0;
  logic        take_first = 1'b0;
  logic [7:0]  q_byte;
  logic        q_valid;
  logic [1:0]  q_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  pq_prefetch_queue dut_i (
    .clk(clk), .rst(rst), .branch_req(branch_req), .branch_addr(branch_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .take(take), .take_first(take_first),
    .q_byte(q_byte), .q_valid(q_valid), .q_status(q_status)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] code_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  function automatic int step_of(input logic [15:0] a);
    return a[0] ? 1 : 2;
  endfunction

  function automatic int fill_level(input logic [15:0] t);
    int lvl = 0;
    logic [15:0] p = t;
    while (DEPTH - lvl >= step_of(p)) begin
      lvl += step_of(p);
      p = p + 16'(step_of(p));
    end
    return lvl;
  endfunction

  // memory model and fetch address checker
  int          lat = 1;
  int          wcnt = 0;
  bit          seen = 0;
  bit          first_fetch = 1;
  bit          redir_pend = 0;
  logic [15:0] redir_addr = '0;
  logic [15:0] exp_addr = '0;
  logic [15:0] txn_addr = '0;
  int          delivered = 0;

  always @(negedge clk) begin
    if (rst) begin
      seen = 0;
      mem_ready = 1'b0;
    end else begin
      if (mem_ready) begin
        seen = 0;
        mem_ready = 1'b0;
        if (redir_pend) begin
          exp_addr = redir_addr;
          redir_pend = 0;
        end else begin
          delivered += step_of(txn_addr);
          exp_addr = txn_addr + 16'(step_of(txn_addr));
        end
      end
      if (mem_req) begin
        if (!seen) begin
          seen = 1;
          wcnt = 0;
          txn_addr = mem_addr;
          chk(mem_addr == exp_addr,
              first_fetch ? "R1 first fetch addr" : (exp_addr[0] ? "R4 fetch addr" : "R3 fetch addr"),
              mem_addr, exp_addr);
          first_fetch = 0;
        end else begin
          chk(mem_addr == txn_addr, "R6 addr held", mem_addr, txn_addr);
        end
        if (wcnt >= lat) begin
          mem_ready = 1'b1;
          mem_rdata = {code_byte({txn_addr[15:1], 1'b1}), code_byte({txn_addr[15:1], 1'b0})};
        end
        wcnt++;
      end
    end
  end

  logic [15:0] cons_addr = '0;

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic do_branch(input logic [15:0] t, input bit with_take);
    tick();
    branch_req = 1'b1;
    branch_addr = t;
    take = with_take;
    take_first = 1'b1;
    if (seen) begin
      redir_pend = 1;
      redir_addr = t;
    end else begin
      exp_addr = t;
    end
    delivered = 0;
    cons_addr = t;
    tick();
    branch_req = 1'b0;
    take = 1'b0;
    chk(q_status == 2'b10, "R10 flush status", q_status, 2);
    chk(!q_valid, "R7 empty after branch", q_valid, 0);
  endtask

  task automatic consume(input bit first);
    int w = 0;
    while (!q_valid && w < 200) begin
      tick();
      w++;
    end
    take = 1'b1;
    take_first = first;
    chk(q_byte == code_byte(cons_addr), "R2 byte order", q_byte, code_byte(cons_addr));
    tick();
    take = 1'b0;
    chk(q_status == (first ? 2'b01 : 2'b11), "R9 take status", q_status, first ? 1 : 3);
    cons_addr = cons_addr + 16'd1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  logic [15:0] targets [6] = '{16'h0000, 16'h0001, 16'h1232, 16'h7FFF, 16'hFFFE, 16'hFFFF};

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(!q_valid, "R1 reset empty", q_valid, 0);
    chk(q_status == 2'b00, "R1 reset status", q_status, 0);
    chk(!mem_req, "R1 reset no request", mem_req, 0);
    tick();
    chk(mem_req, "R1 first request", mem_req, 1);
    repeat (20) tick();
    chk(delivered == fill_level(16'h0000), "R12 reset fill", delivered, fill_level(16'h0000));

    for (int li = 0; li < 3; li++) begin
      lat = li;
      for (int i = 0; i < 6; i++) begin
        do_branch(targets[i], 1'b0);
        // R11 take on empty queue
        take = 1'b1;
        take_first = 1'b1;
        tick();
        take = 1'b0;
        chk(q_status == 2'b00, "R11 empty take status", q_status, 0);
        repeat (30) tick();
        chk(!mem_req, "R5 no request when full", mem_req, 0);
        chk(delivered == fill_level(targets[i]), "R12 idle fill level", delivered, fill_level(targets[i]));
        for (int k = 0; k < 14; k++) begin
          consume(k % 3 == 0);
          if (k % 4 == 1) repeat (2) tick();
        end
      end
      // R8 branch while a fetch is outstanding
      do_branch(16'h4440, 1'b0);
      begin
        int w = 0;
        while (!mem_req && w < 50) begin
          tick();
          w++;
        end
      end
      do_branch(16'h2223, 1'b0);
      for (int k = 0; k < 5; k++) consume(k == 0);
      // R10 take together with a branch
      consume(1'b1);
      do_branch(16'h0ABC, 1'b1);
      for (int k = 0; k < 4; k++) consume(k == 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule